// File: doc/BRIEF.md
# Chained-Slice Synchronous Binary Counter

This block is a wide binary up counter assembled from identical narrow counter slices. Every slice holds a small binary state and takes a count enable, a synchronous active-low clear and a synchronous active-low parallel load. It produces a carry that is high while its state is all ones and its own enable is high. The slices are chained: the first slice's enable is the external count enable, and each later slice is enabled by the carry of the slice below it. The last carry is brought out as the counter's final carry.

All slices run on one common clock, and every state change happens on its rising edge. The carry chain is purely combinational between edges, so it must settle within one clock period. With the default parameters there are two 4-bit slices, which give an 8-bit count. A clear or a load applies to every slice on the same edge. The asynchronous active-low reset is released in step with the clock.

Top module: `chained_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the count is 0x00 and the final carry is low until the first enabled count.
- R2: With clear_n low at a rising edge, the count becomes 0x00 on that edge, whatever load_n and count_en are.
- R3: With clear_n high and load_n low at a rising edge, the count takes load_val on that edge, whatever count_en is.
- R4: With clear_n and load_n high and count_en high, each rising edge adds one to the count.
- R5: With clear_n and load_n high and count_en low, the count holds its value.
- R6: The upper nibble (bits 7:4) advances only on an edge where the lower nibble was 1111 and counting was enabled. On that edge the lower nibble goes to 0000, so 0x0F steps to 0x10.
- R7: The final carry is high exactly while the count is 0xFF and count_en is high.
- R8: The count wraps from 0xFF to 0x00 on an enabled edge.
- R9: With count_en low and the lower nibble at 1111, the upper nibble does not advance and the final carry stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| count_en | input | 1 | Enable for the lowest slice |
| clear_n | input | 1 | Synchronous active-low clear to zero |
| load_n | input | 1 | Synchronous active-low parallel load |
| load_val | input | 8 | Value taken on a load |
| count | output | 8 | Current count |
| carry_out | output | 1 | Final carry of the top slice |

## Verification
The bench builds the counter with its defaults: two slices of four bits each. With those values the whole 256-state range is reachable in a few cycles through a load. That makes the nibble boundary at 0x0F, the full wrap at 0xFF and the clear-over-load-over-count priority cheap to reach. The bench tracks a reference integer on every edge and compares it with the count and the final carry.

// File: rtl/chained_counter_pkg.sv
package chained_counter_pkg;
  typedef struct packed {
    logic clr_n;
    logic ld_n;
    logic en;
  } slice_ctl_t;
endpackage

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/counter_slice.sv
module counter_slice
  import chained_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  slice_ctl_t   ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (!ctl.clr_n)      state_d = '0;
    else if (!ctl.ld_n)  state_d = d;
    else if (ctl.en)     state_d = state_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign q     = state_q;
  assign carry = (&state_q) & ctl.en;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !ctl.clr_n |=> (q == '0));
  assert_load_taken_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (ctl.clr_n && !ctl.ld_n) |=> (q == $past(d)));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (ctl.clr_n && ctl.ld_n && ctl.en) |=> (q == $past(q) + 1'b1));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (ctl.clr_n && ctl.ld_n && !ctl.en) |=> $stable(q));
  assert_carry_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (&q));
endmodule

// File: rtl/chained_counter.sv
module chained_counter
  import chained_counter_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 2,
  localparam int CNT_W     = SLICE_W * NUM_SLICES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             carry_out
);
  logic                   rst_n_int;
  logic [NUM_SLICES:0]    en_chain;
  logic [CNT_W-1:0]       count_w;

  reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign en_chain[0] = count_en;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    slice_ctl_t ctl;
    assign ctl.clr_n = clear_n;
    assign ctl.ld_n  = load_n;
    assign ctl.en    = en_chain[i];

    counter_slice #(.W(SLICE_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n_int),
      .ctl   (ctl),
      .d     (load_val[i*SLICE_W +: SLICE_W]),
      .q     (count_w[i*SLICE_W +: SLICE_W]),
      .carry (en_chain[i+1])
    );
  end

  assign count     = count_w;
  assign carry_out = en_chain[NUM_SLICES];

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) armed_q <= 1'b0;
    else            armed_q <= 1'b1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n_int |-> (count == '0));
  assert_final_carry_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    carry_out |-> ((&count) && count_en));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n_int || !armed_q)
    ((&count) && count_en && clear_n && load_n) |=> (count == '0));
  assert_upper_gated_R9: assert property (@(posedge clk) disable iff (!rst_n_int || !armed_q)
    (clear_n && load_n && !(&count[SLICE_W-1:0] && count_en))
      |=> $stable(count[CNT_W-1:SLICE_W]));
endmodule

// File: tb/chained_counter_test.sv
module chained_counter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       count_en;
  logic       clear_n;
  logic       load_n;
  logic [7:0] load_val;
  logic [7:0] count;
  logic       carry_out;

  int checks = 0;
  int fails  = 0;
  int ref_cnt = 0;

  always #2 clk = ~clk;

  chained_counter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check carry before the rising edge,
  // then check the count just after the rising edge.
  task automatic step(input string req, input logic en, input logic clr,
                      input logic ld, input logic [7:0] d);
    @(negedge clk);
    count_en = en; clear_n = clr; load_n = ld; load_val = d;
    #0.5;
    check({req, " carry"}, int'(carry_out), int'(ref_cnt == 255 && en));
    if (!clr)      ref_cnt = 0;
    else if (!ld)  ref_cnt = d;
    else if (en)   ref_cnt = (ref_cnt + 1) % 256;
    @(posedge clk);
    #0.5;
    check({req, " count"}, int'(count), ref_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; count_en = 1'b0; clear_n = 1'b1; load_n = 1'b1; load_val = 8'h5A;
    repeat (3) @(posedge clk);
    #0.5;
    check("R1 count in reset", int'(count), 0);
    check("R1 carry in reset", int'(carry_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_cnt = 0;
    repeat (3) step("R1 idle after reset", 1'b0, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_nibble_boundary();
    step("R3 load 0x0A", 1'b0, 1'b1, 1'b0, 8'h0A);
    for (int i = 0; i < 10; i++) step("R4 R6 count across 0x0F", 1'b1, 1'b1, 1'b1, 8'h00);
    check("R6 reached 0x14", int'(count), 8'h14);
  endtask

  task automatic t_wrap();
    step("R3 load 0xFD", 1'b1, 1'b1, 1'b0, 8'hFD);
    for (int i = 0; i < 4; i++) step("R7 R8 count through wrap", 1'b1, 1'b1, 1'b1, 8'h00);
    check("R8 after wrap", int'(count), 8'h01);
  endtask

  task automatic t_hold();
    step("R3 load 0x3C", 1'b0, 1'b1, 1'b0, 8'h3C);
    for (int i = 0; i < 4; i++) step("R5 hold", 1'b0, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_disabled_carry();
    step("R3 load 0x2F", 1'b0, 1'b1, 1'b0, 8'h2F);
    for (int i = 0; i < 3; i++) step("R9 disabled at low 1111", 1'b0, 1'b1, 1'b1, 8'h00);
    step("R3 load 0xFF", 1'b0, 1'b1, 1'b0, 8'hFF);
    step("R7 R9 carry low when disabled at 0xFF", 1'b0, 1'b1, 1'b1, 8'h00);
    step("R6 enabled at 0x2F style", 1'b1, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_priority();
    step("R3 load 0x77", 1'b0, 1'b1, 1'b0, 8'h77);
    step("R2 clear beats load and count", 1'b1, 1'b0, 1'b0, 8'hAA);
    step("R3 load beats count", 1'b1, 1'b1, 1'b0, 8'hC3);
    step("R2 clear with count only", 1'b1, 1'b0, 1'b1, 8'h00);
    step("R4 count from zero", 1'b1, 1'b1, 1'b1, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_nibble_boundary();
        t_wrap();
        t_hold();
        t_disabled_carry();
        t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule